// File: doc/BRIEF.md
# Multi-Hart Machine Timer with Mixed-Width Register Access

This block keeps a free-running 64-bit time count and a 64-bit compare value for each hart of a small multi-hart system. For each hart it drives a level interrupt that stays high while the time count is at or above that hart's compare value. Software sets the next deadline by writing the compare register. It can read or adjust the time count through the same register bus.

The bus carries an address, write data, a write enable, a read enable and a size flag that selects a 32-bit or a 64-bit access. Each 64-bit register can be reached as two separate 32-bit halves, which suits a 32-bit core. It can also be reached as a single naturally aligned 64-bit access that reads or replaces the whole value in one cycle. The compare registers occupy consecutive 8-byte slots starting at the compare base, one slot per hart index. The time count sits at its own base address. Reads return data one cycle after the read enable, through a registered output.

Top module: `mach_timer_top`

## Requirements
- R1: While reset is high, and on the cycle after it, the time count is zero, every compare register is all ones, every interrupt output is low and the read data is zero.
- R2: With no write to the time count, each cycle with `tick` high adds one to the count, and the count wraps from all ones to zero.
- R3: A 32-bit write (`size64`=0) to byte offset 0 of a compare slot replaces bits 31:0 from `wdata[31:0]` and leaves bits 63:32 unchanged. A 32-bit write at byte offset 4 replaces bits 63:32 from `wdata[31:0]` and leaves bits 31:0 unchanged.
- R4: A 64-bit write (`size64`=1) to byte offset 0 of a compare slot replaces all 64 bits from `wdata` in one cycle. A 64-bit read there returns all 64 bits.
- R5: A 32-bit read at offset 0 of a slot returns the low half in `rdata[31:0]`. A 32-bit read at offset 4 returns the high half in `rdata[31:0]`. In both cases `rdata[63:32]` is zero.
- R6: The time count at `TIME_BASE` follows the same lane rules for reads and writes (32-bit at offsets 0 and 4, 64-bit at offset 0). A write to it takes effect in place of any increment in that cycle.
- R7: A compare slot whose hart index (address bits `HART_IDX_W+2:3`) is at or above `NUM_HARTS` reads as zero, and writes to it change nothing.
- R8: An access at byte offsets 1, 2, 3, 5, 6 or 7, or a 64-bit access at offset 4, reads as zero and writes nothing.
- R9: `mtip[h]` is high exactly when the time count is greater than or equal to hart h's compare value. It reflects a write on the cycle after that write.
- R10: `rdata` updates one cycle after a cycle with `ren` high and otherwise holds its value. When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; one increment per high cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| rdata | output | 64 | Registered read data |
| mtip | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The hardest case to reach from the ports is a half-width write that lands next to a populated other half. Reaching it requires a compare register that already holds distinct values in both halves, followed by one narrow write. The stimulus handles this with a sweep over every slot index, including unimplemented ones, every byte offset and both sizes. Each write carries a value unique to its slot, offset and size. All implemented harts are read back in full after each write, so a narrow write that clobbers its neighbour half, or a write that leaks into another hart, is caught. The time count gets the same sweep. Separate cases drive a tick together with a time write, wrap the count, and move the interrupt threshold across the count.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int HART_SEL_W = 8;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2,
        LANE_FULL = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TIME = 2'd1,
        TGT_CMP  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e                  tgt;
        lane_e                 lane;
        logic [HART_SEL_W-1:0] hart;
    } acc_s;

    // Combine the old register value with write data for one lane
    function automatic logic [63:0] lane_merge(input logic [63:0] old_v,
                                               input logic [63:0] wd,
                                               input lane_e lane);
        case (lane)
            LANE_LO:   lane_merge = {old_v[63:32], wd[31:0]};
            LANE_HI:   lane_merge = {wd[31:0], old_v[31:0]};
            LANE_FULL: lane_merge = wd;
            default:   lane_merge = old_v;
        endcase
    endfunction

    // Present one lane of a register, zero-extended
    function automatic logic [63:0] lane_view(input logic [63:0] v,
                                              input lane_e lane);
        case (lane)
            LANE_LO:   lane_view = {32'h0, v[31:0]};
            LANE_HI:   lane_view = {32'h0, v[63:32]};
            LANE_FULL: lane_view = v;
            default:   lane_view = 64'h0;
        endcase
    endfunction

endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
    import mtmr_pkg::*;
#(
    parameter int                NUM_HARTS  = 3,
    parameter int                HART_IDX_W = 4,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] CMP_BASE   = '0,
    parameter logic [ADDR_W-1:0] TIME_BASE  = 16'h0100
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size64,
    output acc_s              acc
);
    localparam int CMP_LSB = HART_IDX_W + 3;

    logic                  cmp_win;
    logic                  time_win;
    logic                  idx_ok;
    logic [HART_IDX_W-1:0] idx;
    lane_e                 lane;

    assign idx      = addr[CMP_LSB-1:3];
    assign cmp_win  = (addr[ADDR_W-1:CMP_LSB] == CMP_BASE[ADDR_W-1:CMP_LSB]);
    assign time_win = (addr[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]);
    assign idx_ok   = (32'(idx) < NUM_HARTS);

    always_comb begin
        case (addr[2:0])
            3'd0:    lane = size64 ? LANE_FULL : LANE_LO;
            3'd4:    lane = size64 ? LANE_NONE : LANE_HI;
            default: lane = LANE_NONE;
        endcase
    end

    always_comb begin
        acc.lane = lane;
        acc.hart = HART_SEL_W'(idx);
        if (lane == LANE_NONE)
            acc.tgt = TGT_NONE;
        else if (cmp_win && idx_ok)
            acc.tgt = TGT_CMP;
        else if (time_win)
            acc.tgt = TGT_TIME;
        else
            acc.tgt = TGT_NONE;
    end
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter
    import mtmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  lane_e       wr_lane,
    input  logic [63:0] wdata,
    output logic [63:0] time_q
);
    always_ff @(posedge clk) begin
        if (rst)
            time_q <= 64'h0;
        else if (wr_lane != LANE_NONE)
            time_q <= lane_merge(time_q, wdata, wr_lane);
        else if (tick)
            time_q <= time_q + 64'd1;
    end
endmodule

// File: rtl/mtmr_cmp_bank.sv
module mtmr_cmp_bank
    import mtmr_pkg::*;
#(
    parameter int NUM_HARTS = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  lane_e                          wr_lane,
    input  logic [HART_SEL_W-1:0]          wr_hart,
    input  logic [63:0]                    wdata,
    input  logic [63:0]                    time_q,
    output logic [NUM_HARTS-1:0][63:0]     cmp_q,
    output logic [NUM_HARTS-1:0]           mtip
);
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic hit;
        assign hit = (wr_lane != LANE_NONE) && (wr_hart == HART_SEL_W'(h));

        always_ff @(posedge clk) begin
            if (rst)
                cmp_q[h] <= '1;
            else if (hit)
                cmp_q[h] <= lane_merge(cmp_q[h], wdata, wr_lane);
        end

        assign mtip[h] = (time_q >= cmp_q[h]);
    end
endmodule

// File: rtl/mach_timer_top.sv
module mach_timer_top
    import mtmr_pkg::*;
#(
    parameter int                NUM_HARTS  = 3,
    parameter int                HART_IDX_W = 4,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] CMP_BASE   = '0,
    parameter logic [ADDR_W-1:0] TIME_BASE  = 16'h0100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [63:0]          wdata,
    input  logic                 wen,
    input  logic                 ren,
    input  logic                 size64,
    output logic [63:0]          rdata,
    output logic [NUM_HARTS-1:0] mtip
);
    acc_s                       acc;
    lane_e                      time_wr_lane;
    lane_e                      cmp_wr_lane;
    logic [63:0]                time_q;
    logic [NUM_HARTS-1:0][63:0] cmp_q;
    logic [63:0]                cmp_sel;

    mtmr_decode #(
        .NUM_HARTS  (NUM_HARTS),
        .HART_IDX_W (HART_IDX_W),
        .ADDR_W     (ADDR_W),
        .CMP_BASE   (CMP_BASE),
        .TIME_BASE  (TIME_BASE)
    ) u_decode (
        .addr   (addr),
        .size64 (size64),
        .acc    (acc)
    );

    assign time_wr_lane = (wen && acc.tgt == TGT_TIME) ? acc.lane : LANE_NONE;
    assign cmp_wr_lane  = (wen && acc.tgt == TGT_CMP)  ? acc.lane : LANE_NONE;

    mtmr_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_lane (time_wr_lane),
        .wdata   (wdata),
        .time_q  (time_q)
    );

    mtmr_cmp_bank #(
        .NUM_HARTS (NUM_HARTS)
    ) u_cmp_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_lane (cmp_wr_lane),
        .wr_hart (acc.hart),
        .wdata   (wdata),
        .time_q  (time_q),
        .cmp_q   (cmp_q),
        .mtip    (mtip)
    );

    always_comb begin
        cmp_sel = 64'h0;
        for (int h = 0; h < NUM_HARTS; h++)
            if (acc.hart == HART_SEL_W'(h))
                cmp_sel = cmp_q[h];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 64'h0;
        else if (ren) begin
            case (acc.tgt)
                TGT_TIME: rdata <= lane_view(time_q, acc.lane);
                TGT_CMP:  rdata <= lane_view(cmp_sel, acc.lane);
                default:  rdata <= 64'h0;
            endcase
        end
    end
endmodule

// File: rtl/mtmr_checker.sv
module mtmr_checker #(
    parameter int NUM_HARTS = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           tick,
    input logic                           wen,
    input logic                           ren,
    input logic                           size64,
    input logic [2:0]                     off,
    input logic [63:0]                    rdata,
    input logic [63:0]                    time_q,
    input logic [NUM_HARTS-1:0][63:0]     cmp_q,
    input logic [NUM_HARTS-1:0]           mtip
);
    // R1: reset state appears on the cycle after reset
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (time_q == 64'h0 && rdata == 64'h0 && mtip == '0));

    // R2: a tick without any write adds exactly one
    p_tick_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && !$past(wen)) |-> (time_q == $past(time_q) + 64'd1));

    // R2: no tick and no write keeps the count
    p_time_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick) && !$past(wen)) |-> $stable(time_q));

    // R4: compare registers change only through writes
    p_cmp_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wen)) |-> $stable(cmp_q));

    // R8: odd offsets and 64-bit at offset 4 write nothing
    p_bad_offset_r8: assert property (@(posedge clk) disable iff (rst)
        (wen && off != 3'd0 && !(off == 3'd4 && !size64)) |=> $stable(cmp_q));

    // R10: read data holds without a read
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ren)) |-> $stable(rdata));

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_lane
        // R3: a low-half write keeps every high half
        p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (rst)
            (wen && !size64 && off == 3'd0) |=> $stable(cmp_q[h][63:32]));
        // R3: a high-half write keeps every low half
        p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (rst)
            (wen && !size64 && off == 3'd4) |=> $stable(cmp_q[h][31:0]));
    end
endmodule

bind mach_timer_top mtmr_checker #(.NUM_HARTS(NUM_HARTS)) u_checker (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wen    (wen),
    .ren    (ren),
    .size64 (size64),
    .off    (addr[2:0]),
    .rdata  (rdata),
    .time_q (time_q),
    .cmp_q  (cmp_q),
    .mtip   (mtip)
);

// File: tb/mach_timer_top_tb_top.sv
`timescale 1ns/1ps
module mach_timer_top_tb_top;
    localparam int NH = 3;
    localparam logic [15:0] TBASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [15:0] addr = '0;
    logic [63:0] wdata = '0;
    logic        wen = 1'b0;
    logic        ren = 1'b0;
    logic        size64 = 1'b0;
    logic [63:0] rdata;
    logic [NH-1:0] mtip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_time;
    logic [63:0] m_cmp [NH];

    always #2.5 clk = ~clk;

    mach_timer_top #(
        .NUM_HARTS(NH), .HART_IDX_W(4), .ADDR_W(16),
        .CMP_BASE(16'h0000), .TIME_BASE(TBASE)
    ) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wdata(wdata),
        .wen(wen), .ren(ren), .size64(size64), .rdata(rdata), .mtip(mtip)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // lane code: 0 none, 1 low, 2 high, 3 full
    function automatic int lane_of(input logic [15:0] a, input logic s64);
        if (a[2:0] == 3'd0) return s64 ? 3 : 1;
        if (a[2:0] == 3'd4) return s64 ? 0 : 2;
        return 0;
    endfunction

    // returns -2 none, -1 time, else hart index
    function automatic int tgt_of(input logic [15:0] a);
        if (a[15:7] == 9'd0) return (int'(a[6:3]) < NH) ? int'(a[6:3]) : -2;
        if (a[15:3] == TBASE[15:3]) return -1;
        return -2;
    endfunction

    function automatic logic [63:0] upd(input logic [63:0] o, input logic [63:0] d, input int ln);
        if (ln == 1) return {o[63:32], d[31:0]};
        if (ln == 2) return {d[31:0], o[31:0]};
        if (ln == 3) return d;
        return o;
    endfunction

    function automatic logic [63:0] exp_read(input logic [15:0] a, input logic s64);
        int ln = lane_of(a, s64);
        int t = tgt_of(a);
        logic [63:0] v;
        if (ln == 0 || t == -2) return 64'h0;
        v = (t == -1) ? m_time : m_cmp[t];
        if (ln == 1) return {32'h0, v[31:0]};
        if (ln == 2) return {32'h0, v[63:32]};
        return v;
    endfunction

    task automatic model_write(input logic [15:0] a, input logic s64, input logic [63:0] d);
        int ln = lane_of(a, s64);
        int t = tgt_of(a);
        if (ln == 0 || t == -2) return;
        if (t == -1) m_time = upd(m_time, d, ln);
        else m_cmp[t] = upd(m_cmp[t], d, ln);
    endtask

    task automatic do_write(input logic [15:0] a, input logic s64, input logic [63:0] d);
        addr = a; size64 = s64; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
        model_write(a, s64, d);
    endtask

    task automatic do_read(input logic [15:0] a, input logic s64, output logic [63:0] q);
        addr = a; size64 = s64; ren = 1'b1;
        @(negedge clk);
        q = rdata;
        ren = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        m_time = m_time + 64'd1;
    endtask

    task automatic chk_irq(input string req);
        for (int h = 0; h < NH; h++)
            chk(req, 64'(mtip[h]), 64'(m_time >= m_cmp[h]));
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [63:0] q;
        logic [63:0] held;
        logic [63:0] d;
        m_time = 64'h0;
        for (int h = 0; h < NH; h++) m_cmp[h] = '1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1 rdata", rdata, 64'h0);
        chk("R1 mtip", 64'(mtip), 64'h0);
        do_read(TBASE, 1'b1, q); chk("R1 time", q, 64'h0);
        for (int h = 0; h < NH; h++) begin
            do_read(16'(h * 8), 1'b1, q); chk("R1 cmp", q, '1);
        end

        // R3 R4 R5 R7 R8: sweep every slot, offset and size on the compare region
        for (int slot = 0; slot < 16; slot++)
            for (int off = 0; off < 8; off++)
                for (int s = 0; s < 2; s++) begin
                    logic [15:0] a = 16'(slot * 8 + off);
                    d = {32'hC000_0000 | 32'(slot << 12) | 32'(off << 4) | 32'(s),
                         32'h3000_0000 | 32'(slot << 8) | 32'(off << 20) | 32'(s << 2)};
                    do_write(a, s[0], d);
                    for (int h = 0; h < NH; h++) begin
                        do_read(16'(h * 8), 1'b1, q);
                        chk("R3/R4/R7/R8 cmp readback", q, m_cmp[h]);
                    end
                    do_read(a, s[0], q);
                    chk("R5/R7/R8 same-address read", q, exp_read(a, s[0]));
                    chk_irq("R9 sweep");
                end

        // R6: time region, every offset and size
        for (int off = 0; off < 8; off++)
            for (int s = 0; s < 2; s++) begin
                logic [15:0] a = TBASE + 16'(off);
                d = {32'h0000_00A0 | 32'(off), 32'h0B00_0000 | 32'(off << 8) | 32'(s)};
                do_write(a, s[0], d);
                do_read(TBASE, 1'b1, q); chk("R6 time full", q, m_time);
                do_read(TBASE, 1'b0, q); chk("R6 time low", q, {32'h0, m_time[31:0]});
                do_read(TBASE + 16'd4, 1'b0, q); chk("R6 time high", q, {32'h0, m_time[63:32]});
                do_read(a, s[0], q); chk("R6/R8 time same-address", q, exp_read(a, s[0]));
            end

        // R2: wrap through all ones
        do_write(TBASE, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        for (int i = 0; i < 3; i++) pulse_tick();
        do_read(TBASE, 1'b1, q); chk("R2 wrap", q, 64'h1);
        chk("R2 wrap model", m_time, 64'h1);

        // R6: write wins over a tick in the same cycle
        tick = 1'b1;
        do_write(TBASE, 1'b1, 64'h0000_0001_0000_0010);
        tick = 1'b0;
        do_read(TBASE, 1'b1, q); chk("R6 write over tick", q, 64'h0000_0001_0000_0010);
        // R6: carry from low half into high half by tick
        do_write(TBASE, 1'b1, 64'h0000_0001_FFFF_FFFF);
        pulse_tick();
        do_read(TBASE + 16'd4, 1'b0, q); chk("R2 carry high", q, 64'h2);

        // R9: threshold crossing on hart 1 by ticks and by compare writes
        do_write(16'h0000, 1'b1, '1);
        do_write(16'h0008, 1'b1, 64'd20);
        do_write(16'h0010, 1'b1, '1);
        do_write(TBASE, 1'b1, 64'd18);
        chk_irq("R9 below");
        chk("R9 h1 low", 64'(mtip[1]), 64'h0);
        pulse_tick(); chk("R9 still below", 64'(mtip[1]), 64'h0);
        pulse_tick(); chk("R9 equal", 64'(mtip[1]), 64'h1);
        pulse_tick(); chk_irq("R9 above");
        do_write(16'h000C, 1'b0, 64'h1); chk("R9 cleared by high write", 64'(mtip[1]), 64'h0);
        do_write(16'h000C, 1'b0, 64'h0); chk("R9 set by high write", 64'(mtip[1]), 64'h1);
        do_write(16'h0000, 1'b0, 64'd5);
        do_write(16'h0004, 1'b0, 64'd0); chk("R9 hart0 via halves", 64'(mtip[0]), 64'h1);
        chk_irq("R9 final");

        // R10: read concurrent with write returns old value; rdata holds
        addr = 16'h0010; size64 = 1'b1; wdata = 64'h1234_5678_9ABC_DEF0;
        wen = 1'b1; ren = 1'b1;
        @(negedge clk);
        wen = 1'b0; ren = 1'b0;
        chk("R10 read-before-write", rdata, m_cmp[2]);
        model_write(16'h0010, 1'b1, 64'h1234_5678_9ABC_DEF0);
        held = rdata;
        do_write(16'h0008, 1'b1, 64'h77);
        pulse_tick();
        chk("R10 hold", rdata, held);
        do_read(16'h0010, 1'b1, q); chk("R10 new value", q, 64'h1234_5678_9ABC_DEF0);

        // R1: reset again restores the initial state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_time = 64'h0;
        for (int h = 0; h < NH; h++) m_cmp[h] = '1;
        chk("R1 second reset rdata", rdata, 64'h0);
        chk("R1 second reset mtip", 64'(mtip), 64'h0);
        do_read(16'h0008, 1'b1, q); chk("R1 second reset cmp", q, '1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule